// File: doc/BRIEF.md
# Randomized Playback Scheduler

This block decides when a downstream audio player is told to start a clip. It has two operating modes chosen by a single mode pin. In trigger mode it sits idle until a detection strobe arrives, then requests playback of the clip whose index is present on the clip input at that moment. Each trigger-mode playback is followed by a one-cycle record strobe, which the surrounding system uses to report the event upstream. In random mode the block needs no outside event. Before every playback it draws a new pseudo-random wait from a programmable range, counts that wait down in units of an external tick enable, and then issues the request. Nodes that share a configuration therefore do not fall into step.

The play request leaves the block as a valid/ready stream whose payload is the clip index. Once `play_valid` rises, it stays high and `play_clip` stays unchanged until a cycle in which `play_ready` is high. The transfer completes in that cycle. A low `play_ready` stalls the block for as long as it stays low. The player-busy flag is a plain status input. After each transfer the block waits for that flag to be seen low before it accepts a new detection or draws a new random wait. The mode, the range limits and the clip index are plain level inputs that may change at any time.

Top module: `playback_scheduler`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `play_valid` and `rec_strobe` are 0. The random generator returns to its seed value.
- R2: In trigger mode (`mode_random`=0), when the block is idle, a cycle with `detect`=1 and `player_busy`=0 raises `play_valid` after the next clock edge. `play_clip` then equals the `clip_idx` value sampled in the cycle of the detection.
- R3: A `detect` pulse has no effect in two cases: when `player_busy` is 1 in trigger mode, and at any time in random mode. A random-mode countdown is neither shortened nor restarted by it.
- R4: In random mode the wait is d = min + (r mod (max − min + 1)).
  - r is the current 16-bit generator state. The generator is a right-shifting Galois LFSR with feedback mask 0xB400, seeded to 0xACE1, and it advances once per draw.
  - If max ≤ min, then d = min.
  - With `tick` held at 1 and `play_ready` at 1, the first request after switching into random mode from idle appears d+3 cycles after the switch.
- R5: The countdown advances only in cycles where `tick`=1. With `tick` held at 0, a random-mode request never issues.
- R6: One cycle after each trigger-mode transfer (`play_valid` and `play_ready` both 1), `rec_strobe` is 1 for exactly one cycle. A random-mode transfer never produces it.
- R7: If the mode changes while a random countdown is in progress, the countdown is abandoned and no request results from it.
- R8: After any transfer, no new detection is accepted and no new wait is drawn until `player_busy` has been seen low in a cycle after that transfer. With a zero wait, the next random request appears 3 cycles after `player_busy` falls.
- R9: While `play_valid`=1 and `play_ready`=0, `play_valid` stays 1 and `play_clip` stays constant in the next cycle, even if `clip_idx` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_random | input | 1 | 1 = random mode, 0 = trigger mode |
| wait_min | input | DLY_W | Lower bound of random wait, in ticks |
| wait_max | input | DLY_W | Upper bound of random wait, in ticks |
| clip_idx | input | CLIP_W | Most recently written target clip |
| tick | input | 1 | Delay-unit enable for the countdown |
| detect | input | 1 | Detection event strobe |
| player_busy | input | 1 | Player is still playing |
| play_ready | input | 1 | Player accepts the request |
| play_valid | output | 1 | Playback request valid |
| play_clip | output | CLIP_W | Clip index of the request |
| rec_strobe | output | 1 | Execution record pulse after a trigger playback |

## Verification
Some properties are checked by assertions on every cycle:
- the hold rule of the request stream;
- that each record pulse is single and follows a completed transfer;
- that any trigger-mode request was caused by an accepted detection;
- the quiet outputs during reset.

Other behaviour can only be shown by the bench's scenarios:
- the exact length of each random wait against an independent model of the generator and the range mapping;
- the degenerate ranges;
- abandoning a countdown on a mode change;
- the stall while ticks are withheld;
- the cooldown behind the busy flag.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_COOL  = 2'd3
  } sched_state_e;
endpackage

// File: rtl/sched_lfsr.sv
// Galois LFSR, advances only when step is high.
module sched_lfsr #(
  parameter int            W     = 16,
  parameter logic [W-1:0]  TAPS  = 16'hB400,
  parameter logic [W-1:0]  SEED  = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  assign value = state_q;
endmodule

// File: rtl/sched_range_map.sv
// Folds a random word into [lo, hi]; returns lo when the range is empty or a single point.
module sched_range_map #(
  parameter int RW = 16,
  parameter int DW = 8
) (
  input  logic [RW-1:0] rnd,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] delay
);
  localparam int SW = DW + 1;

  logic [SW-1:0] span;
  logic [RW-1:0] span_ext;
  logic [RW-1:0] offset;

  always_comb begin
    span     = {1'b0, hi} - {1'b0, lo} + SW'(1);
    span_ext = RW'(span);
    offset   = '0;
    delay    = lo;
    if (hi > lo) begin
      offset = rnd % span_ext;
      delay  = lo + offset[DW-1:0];
    end
  end
endmodule

// File: rtl/sched_countdown.sv
// Loadable down-counter stepping on tick; zero flags the end of the wait.
module sched_countdown #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - DW'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/playback_scheduler.sv
module playback_scheduler
  import sched_pkg::*;
#(
  parameter int                DLY_W    = 8,
  parameter int                CLIP_W   = 6,
  parameter int                RND_W    = 16,
  parameter logic [RND_W-1:0]  RND_TAPS = 16'hB400,
  parameter logic [RND_W-1:0]  RND_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_random,
  input  logic [DLY_W-1:0]  wait_min,
  input  logic [DLY_W-1:0]  wait_max,
  input  logic [CLIP_W-1:0] clip_idx,
  input  logic              tick,
  input  logic              detect,
  input  logic              player_busy,
  input  logic              play_ready,
  output logic              play_valid,
  output logic [CLIP_W-1:0] play_clip,
  output logic              rec_strobe
);
  sched_state_e      state_q, state_d;
  logic              mode_q;
  logic              mode_chg;
  logic              draw;
  logic              fire_trig;
  logic              fire_rand;
  logic              handshake;
  logic              cnt_zero;
  logic              trig_src_q;
  logic [CLIP_W-1:0] clip_q;
  logic [RND_W-1:0]  rnd;
  logic [DLY_W-1:0]  delay;

  sched_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(draw), .value(rnd)
  );

  sched_range_map #(.RW(RND_W), .DW(DLY_W)) u_map (
    .rnd(rnd), .lo(wait_min), .hi(wait_max), .delay(delay)
  );

  sched_countdown #(.DW(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(draw), .load_val(delay),
    .tick(tick), .zero(cnt_zero)
  );

  assign mode_chg  = (mode_random != mode_q);
  assign handshake = (state_q == ST_ISSUE) && play_ready;
  assign draw      = (state_q == ST_IDLE) && mode_random && !mode_chg;
  assign fire_trig = (state_q == ST_IDLE) && !mode_random && detect && !player_busy;
  assign fire_rand = (state_q == ST_WAIT) && !mode_chg && cnt_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (draw)           state_d = ST_WAIT;
                else if (fire_trig) state_d = ST_ISSUE;
      ST_WAIT:  if (mode_chg)       state_d = ST_IDLE;
                else if (cnt_zero)  state_d = ST_ISSUE;
      ST_ISSUE: if (play_ready)     state_d = ST_COOL;
      ST_COOL:  if (!player_busy)   state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      clip_q     <= '0;
      trig_src_q <= 1'b0;
      rec_strobe <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_random;
      rec_strobe <= handshake && trig_src_q;
      if (fire_trig || fire_rand) begin
        clip_q     <= clip_idx;
        trig_src_q <= fire_trig;
      end
    end
  end

  assign play_valid = (state_q == ST_ISSUE);
  assign play_clip  = clip_q;
endmodule

// File: rtl/playback_scheduler_chk.sv
module playback_scheduler_chk #(
  parameter int CLIP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_random,
  input logic              detect,
  input logic              player_busy,
  input logic              play_ready,
  input logic              play_valid,
  input logic [CLIP_W-1:0] play_clip,
  input logic              rec_strobe
);
  // R1
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !play_valid && !rec_strobe);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid && !play_ready |=> play_valid && $stable(play_clip));

  // R6
  rec_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_strobe |-> $past(play_valid && play_ready));

  // R6
  rec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_strobe |=> !rec_strobe);

  // R2
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_valid) && !mode_random && !$past(mode_random)
      |-> $past(detect && !player_busy));
endmodule

bind playback_scheduler playback_scheduler_chk #(.CLIP_W(CLIP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_random(mode_random), .detect(detect),
  .player_busy(player_busy), .play_ready(play_ready), .play_valid(play_valid),
  .play_clip(play_clip), .rec_strobe(rec_strobe)
);

// File: tb/playback_scheduler_tb.sv
module playback_scheduler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_random = 1'b0;
  logic [DW-1:0] wait_min = '0;
  logic [DW-1:0] wait_max = '0;
  logic [CW-1:0] clip_idx = '0;
  logic          tick = 1'b1;
  logic          detect = 1'b0;
  logic          player_busy = 1'b0;
  logic          play_ready = 1'b1;
  logic          play_valid;
  logic [CW-1:0] play_clip;
  logic          rec_strobe;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr_m = 16'hACE1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  playback_scheduler u_dut (
    .clk(clk), .rst_n(rst_n), .mode_random(mode_random), .wait_min(wait_min),
    .wait_max(wait_max), .clip_idx(clip_idx), .tick(tick), .detect(detect),
    .player_busy(player_busy), .play_ready(play_ready), .play_valid(play_valid),
    .play_clip(play_clip), .rec_strobe(rec_strobe)
  );

  // {busy, detect, expect_play, clip[5:0]}
  localparam logic [8:0] TRIG_TBL [6] = '{
    {1'b0, 1'b1, 1'b1, 6'd5},
    {1'b1, 1'b1, 1'b0, 6'd9},
    {1'b0, 1'b1, 1'b1, 6'd63},
    {1'b0, 1'b0, 1'b0, 6'd12},
    {1'b1, 1'b1, 1'b0, 6'd0},
    {1'b0, 1'b1, 1'b1, 6'd0}
  };

  // {min, max}
  localparam logic [15:0] RANGE_TBL [6] = '{
    {8'd3,   8'd9},
    {8'd7,   8'd7},
    {8'd20,  8'd10},
    {8'd0,   8'd255},
    {8'd100, 8'd140},
    {8'd0,   8'd0}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Model draw: map current state into range, then advance.
  function automatic int model_draw(input int lo, input int hi);
    int d;
    if (hi <= lo) d = lo;
    else          d = lo + (int'(lfsr_m) % (hi - lo + 1));
    lfsr_m = (lfsr_m >> 1) ^ (lfsr_m[0] ? 16'hB400 : 16'h0000);
    return d;
  endfunction

  task automatic wait_play(output int n, input int limit);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!play_valid && n < limit);
  endtask

  task automatic go_idle();
    mode_random = 1'b0;
    player_busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    int d;
    int seen;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(play_valid), 0);
    check("R1 rec in reset", int'(rec_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(play_valid), 0);

    // Trigger table: R2, R3, R6
    for (int i = 0; i < 6; i++) begin
      player_busy = TRIG_TBL[i][8];
      detect      = TRIG_TBL[i][7];
      clip_idx    = TRIG_TBL[i][5:0];
      @(negedge clk);
      detect = 1'b0;
      check($sformatf("R2/R3 play entry %0d", i), int'(play_valid), int'(TRIG_TBL[i][6]));
      if (TRIG_TBL[i][6]) check($sformatf("R2 clip entry %0d", i), int'(play_clip), int'(TRIG_TBL[i][5:0]));
      @(negedge clk);
      check($sformatf("R6 rec entry %0d", i), int'(rec_strobe), int'(TRIG_TBL[i][6]));
      player_busy = 1'b0;
      @(negedge clk);
      check($sformatf("R6 rec single entry %0d", i), int'(rec_strobe), 0);
      repeat (2) @(negedge clk);
    end

    // R9 back-pressure with clip change
    play_ready = 1'b0;
    clip_idx = 6'd17;
    detect = 1'b1;
    @(negedge clk);
    detect = 1'b0;
    clip_idx = 6'd40;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 valid held", int'(play_valid), 1);
      check("R9 clip stable", int'(play_clip), 17);
      check("R6 no rec while stalled", int'(rec_strobe), 0);
    end
    play_ready = 1'b1;
    @(negedge clk);
    check("R6 rec after stall", int'(rec_strobe), 1);
    check("R9 valid drops after accept", int'(play_valid), 0);
    go_idle();

    // R4 / R8-range table
    for (int i = 0; i < 6; i++) begin
      wait_min = RANGE_TBL[i][15:8];
      wait_max = RANGE_TBL[i][7:0];
      clip_idx = CW'(i + 30);
      @(negedge clk);
      mode_random = 1'b1;
      d = model_draw(int'(RANGE_TBL[i][15:8]), int'(RANGE_TBL[i][7:0]));
      wait_play(n, 600);
      check($sformatf("R4 wait entry %0d", i), n, d + 3);
      check($sformatf("R4 clip entry %0d", i), int'(play_clip), i + 30);
      mode_random = 1'b0;
      @(negedge clk);
      check($sformatf("R6 no rec random %0d", i), int'(rec_strobe), 0);
      go_idle();
    end

    // R8 cooldown behind busy
    wait_min = 8'd0;
    wait_max = 8'd0;
    @(negedge clk);
    mode_random = 1'b1;
    d = model_draw(0, 0);
    wait_play(n, 50);
    check("R8 first zero wait", n, 3);
    player_busy = 1'b1;
    seen = 0;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (play_valid) seen++;
    end
    check("R8 no draw while busy", seen, 0);
    player_busy = 1'b0;
    d = model_draw(0, 0);
    wait_play(n, 50);
    check("R8 request after busy falls", n, 3);
    go_idle();

    // R7 abort on mode change
    wait_min = 8'd100;
    wait_max = 8'd100;
    @(negedge clk);
    mode_random = 1'b1;
    d = model_draw(100, 100);
    repeat (20) @(negedge clk);
    mode_random = 1'b0;
    seen = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (play_valid) seen++;
    end
    check("R7 aborted countdown silent", seen, 0);

    // R3 detect ignored in random mode
    wait_min = 8'd30;
    wait_max = 8'd30;
    @(negedge clk);
    mode_random = 1'b1;
    d = model_draw(30, 30);
    n = 0;
    do begin
      detect = (n == 5 || n == 10);
      @(negedge clk);
      n++;
    end while (!play_valid && n < 200);
    detect = 1'b0;
    check("R3 random detect ignored", n, d + 3);
    go_idle();

    // R5 tick gating
    tick = 1'b0;
    wait_min = 8'd5;
    wait_max = 8'd5;
    @(negedge clk);
    mode_random = 1'b1;
    d = model_draw(5, 5);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (play_valid) seen++;
    end
    check("R5 no request without tick", seen, 0);
    tick = 1'b1;
    wait_play(n, 50);
    check("R5 request after ticks resume", n, d + 1);
    go_idle();

    // R1 mid-run reset clears a pending request and reseeds
    play_ready = 1'b0;
    clip_idx = 6'd3;
    detect = 1'b1;
    @(negedge clk);
    detect = 1'b0;
    check("R1 pending before reset", int'(play_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid cleared by reset", int'(play_valid), 0);
    rst_n = 1'b1;
    play_ready = 1'b1;
    lfsr_m = 16'hACE1;
    wait_min = 8'd3;
    wait_max = 8'd9;
    @(negedge clk);
    mode_random = 1'b1;
    d = model_draw(3, 9);
    wait_play(n, 100);
    check("R1 reseeded draw", n, d + 3);
    go_idle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule